// File: doc/BRIEF.md
# Single-Lane Vector Structure Load/Store Sequencer

This unit carries out one vector structure transfer at a time: a structure of one to four elements is moved between memory and one lane of consecutive vector registers. It is handed the raw size-related instruction fields. These are the 128/64-bit width bit, the load/store bit, the element-count bit, a three-bit opcode, the lane bit and the two-bit size field, plus three register numbers and a post-index flag. From these it derives the element size, the lane index, the element count and whether the load replicates. It then walks the elements one memory access at a time. Each access sits at the next element-sized byte offset, and the register numbers wrap modulo 32.

On a lane load, the unit reads the whole register, merges the returned element into the chosen lane and writes the register back. On a replicating load, it fills every lane of the register with the element. On a store, it puts the lane value on the memory data bus. In the post-index form, the base register is then advanced. The step is either the structure size or the value of an offset register. Undefined field combinations and a misaligned stack-pointer base are refused before any access is made.

Top module: `lane_struct_seq`

## Requirements
- R1: The opcode bits [2:1] select the element scale (element bytes = 1 << scale) and {opcode[0], R} + 1 gives the element count. Byte elements use lane {Q,S,size}. Halfword elements use lane {Q,S,size[1]}. Word elements (scale 2, size 00) use lane {Q,S}. Scale 2 with size 01 becomes a doubleword (scale 3) with lane Q.
- R2: These encodings are undefined: halfword with size[0]=1, scale 2 with size[1]=1, doubleword with S=1, and replicate (opcode[2:1]=3) with a store or with S=1. In each case `undef` pulses high for one cycle in the cycle after `start`, and no memory request, register write or base write occurs.
- R3: Element s accesses address base + s × element bytes, with `mem_size` = scale, and targets vector register (Rt + s) mod 32. Elements are issued in increasing s.
- R4: A lane load changes only the bytes of the selected lane. Element byte k is taken from bits [8k+7:8k] of `mem_rdata` (little-endian), and the bytes above the element size are ignored.
- R5: A replicating load (opcode[2:1]=3) takes its scale from the size field. It writes the element into every lane of the low 128 bits when Q=1. When Q=0 it fills the low 64 bits and clears the upper 64 bits.
- R6: A store drives the selected lane, little-endian, in the low bytes of `mem_wdata`, with all higher bits zero. It writes no vector register.
- R7: When Rn is 31, the base is the stack pointer (general register index 31). If its low four bits are not zero, `align_fault` pulses high for one cycle in the cycle after `start`, and nothing is accessed or written.
- R8: In the post-index form, after the last element the base register Rn gets base + (count × element bytes) when Rm is 31, and base + GPR[Rm] otherwise. GPR[Rm] is sampled at `start`.
- R9: The no-offset form never writes the base register.
- R10: At most one memory request is outstanding. A new request is raised only after `mem_rvalid` has answered the previous one, and each request lasts one cycle.
- R11: `done` pulses for one cycle. It comes the cycle after the last response, or the cycle after the base write in the post-index form. `busy` is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer with the field inputs below (ignored while busy) |
| ins_q | input | 1 | 128-bit (1) or 64-bit (0) register width bit |
| ins_load | input | 1 | 1 = load, 0 = store |
| ins_r | input | 1 | Low bit of element count |
| ins_opc | input | 3 | Opcode field |
| ins_s | input | 1 | Lane bit S |
| ins_size | input | 2 | Size field |
| ins_rt | input | 5 | First vector register |
| ins_rn | input | 5 | Base register (31 = stack pointer) |
| ins_rm | input | 5 | Post-index register (31 = immediate step) |
| ins_post | input | 1 | Post-index writeback form |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed pulse |
| undef | output | 1 | Undefined encoding pulse |
| align_fault | output | 1 | Stack-pointer misalignment pulse |
| gpr_base_idx | output | 5 | General register read index for the base |
| gpr_base_val | input | 64 | Base register value |
| gpr_off_idx | output | 5 | General register read index for the offset |
| gpr_off_val | input | 64 | Offset register value |
| base_we | output | 1 | Base register write strobe |
| base_widx | output | 5 | Base register write index |
| base_wval | output | 64 | Updated base value |
| vr_idx | output | 5 | Vector register index (read and write) |
| vr_rdata | input | 128 | Vector register read data |
| vr_we | output | 1 | Vector register write strobe |
| vr_wdata | output | 128 | Vector register write data |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | log2 of access bytes |
| mem_addr | output | 64 | Access byte address |
| mem_wdata | output | 64 | Store data, little-endian |
| mem_rvalid | input | 1 | Response / acknowledge |
| mem_rdata | input | 64 | Load data, little-endian |

## Verification
The bench builds the unit with its default parameters: 64-bit addresses, 128-bit registers, a 64-bit memory bus, 32 registers and 16-byte stack alignment. With these defaults the full field space is small enough to sweep completely. Every combination of opcode, R, S, size, Q, load/store and writeback form is run with the first register moving round the file, so the modulo-32 wrap at register 31 is exercised. Stack-pointer bases alternate between aligned and misaligned values, and memory latency alternates between one and two cycles. Register file, base register and store traffic are all compared against an arithmetic model.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int LANE_W = 4;

  typedef struct packed {
    logic [1:0]        scale;
    logic [2:0]        nelem;
    logic [LANE_W-1:0] lane;
    logic              rep;
    logic              undef;
  } lss_dec_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_WB,
    ST_FIN
  } lss_st_t;
endpackage

// File: rtl/lss_decode.sv
module lss_decode
  import lss_pkg::*;
(
  input  logic       q,
  input  logic       s,
  input  logic       r,
  input  logic       load,
  input  logic [2:0] opc,
  input  logic [1:0] size,
  output lss_dec_t   dec
);
  always_comb begin
    dec.scale = opc[2:1];
    dec.nelem = {1'b0, opc[0], r} + 3'd1;
    dec.lane  = '0;
    dec.rep   = 1'b0;
    dec.undef = 1'b0;
    case (opc[2:1])
      2'd0: dec.lane = {q, s, size};
      2'd1: begin
        dec.undef = size[0];
        dec.lane  = {1'b0, q, s, size[1]};
      end
      2'd2: begin
        if (size[1]) begin
          dec.undef = 1'b1;
        end else if (!size[0]) begin
          dec.lane = {2'b00, q, s};
        end else begin
          dec.undef = s;
          dec.lane  = {3'b000, q};
          dec.scale = 2'd3;
        end
      end
      default: begin
        dec.undef = !load || s;
        dec.scale = size;
        dec.rep   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lss_lane.sv
module lss_lane #(
  parameter int VW = 128,
  parameter int DW = 64
) (
  input  logic [VW-1:0] old,
  input  logic [DW-1:0] elem,
  input  logic [3:0]    lane,
  input  logic [1:0]    scale,
  input  logic          rep,
  input  logic          wide,
  output logic [VW-1:0] merged,
  output logic [DW-1:0] extracted
);
  localparam int SW = $clog2(VW);
  localparam int HW = VW / 2;

  logic [DW-1:0] emask;
  logic [SW-1:0] shift;
  logic [VW-1:0] ins_v, ins_m, lane_v, rep_sel, rep_fill;
  logic [VW-1:0] rep_v [4];

  always_comb begin
    case (scale)
      2'd0:    emask = DW'({8{1'b1}});
      2'd1:    emask = DW'({16{1'b1}});
      2'd2:    emask = DW'({32{1'b1}});
      default: emask = {DW{1'b1}};
    endcase
  end

  assign shift = SW'(lane) << (3'd3 + 3'(scale));
  assign ins_v  = VW'(elem & emask) << shift;
  assign ins_m  = VW'(emask) << shift;
  assign lane_v = (old & ~ins_m) | ins_v;
  assign extracted = DW'(old >> shift) & emask;

  for (genvar g = 0; g < 4; g++) begin : g_rep
    localparam int EW = 8 << g;
    assign rep_v[g] = {(VW / EW){elem[EW-1:0]}};
  end

  assign rep_sel  = rep_v[scale];
  assign rep_fill = wide ? rep_sel : {{HW{1'b0}}, rep_sel[HW-1:0]};
  assign merged   = rep ? rep_fill : lane_v;
endmodule

// File: rtl/lane_struct_seq.sv
module lane_struct_seq
  import lss_pkg::*;
#(
  parameter int AW       = 64,
  parameter int VW       = 128,
  parameter int DW       = 64,
  parameter int NR       = 32,
  parameter int SP_ALIGN = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   ins_q,
  input  logic                   ins_load,
  input  logic                   ins_r,
  input  logic [2:0]             ins_opc,
  input  logic                   ins_s,
  input  logic [1:0]             ins_size,
  input  logic [$clog2(NR)-1:0]  ins_rt,
  input  logic [$clog2(NR)-1:0]  ins_rn,
  input  logic [$clog2(NR)-1:0]  ins_rm,
  input  logic                   ins_post,
  output logic                   busy,
  output logic                   done,
  output logic                   undef,
  output logic                   align_fault,
  output logic [$clog2(NR)-1:0]  gpr_base_idx,
  input  logic [AW-1:0]          gpr_base_val,
  output logic [$clog2(NR)-1:0]  gpr_off_idx,
  input  logic [AW-1:0]          gpr_off_val,
  output logic                   base_we,
  output logic [$clog2(NR)-1:0]  base_widx,
  output logic [AW-1:0]          base_wval,
  output logic [$clog2(NR)-1:0]  vr_idx,
  input  logic [VW-1:0]          vr_rdata,
  output logic                   vr_we,
  output logic [VW-1:0]          vr_wdata,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [1:0]             mem_size,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic                   mem_rvalid,
  input  logic [DW-1:0]          mem_rdata
);
  localparam int RW = $clog2(NR);
  localparam int AL = $clog2(SP_ALIGN);
  localparam logic [RW-1:0] SP_IDX = RW'(NR - 1);

  lss_dec_t dec, dec_q;
  lss_st_t  st_q, st_d;

  logic          accept, step, last;
  logic          undef_d, fault_d, undef_q, fault_q;
  logic          load_q, wide_q, post_q, imm_q;
  logic [RW-1:0] rn_q, reg_q;
  logic [2:0]    elem_q;
  logic [AW-1:0] addr_q, base_q, off_q, ebytes, total;
  logic [DW-1:0] lane_out;
  logic [VW-1:0] merged;

  lss_decode i_dec (
    .q    (ins_q),
    .s    (ins_s),
    .r    (ins_r),
    .load (ins_load),
    .opc  (ins_opc),
    .size (ins_size),
    .dec  (dec)
  );

  lss_lane #(.VW(VW), .DW(DW)) i_lane (
    .old       (vr_rdata),
    .elem      (mem_rdata),
    .lane      (dec_q.lane),
    .scale     (dec_q.scale),
    .rep       (dec_q.rep),
    .wide      (wide_q),
    .merged    (merged),
    .extracted (lane_out)
  );

  assign ebytes = AW'(1) << dec_q.scale;
  assign total  = AW'(dec_q.nelem) << dec_q.scale;
  assign last   = (elem_q == dec_q.nelem - 3'd1);

  // next-state logic
  always_comb begin
    st_d    = st_q;
    accept  = 1'b0;
    step    = 1'b0;
    undef_d = 1'b0;
    fault_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (dec.undef) begin
            undef_d = 1'b1;
          end else if (ins_rn == SP_IDX && |gpr_base_val[AL-1:0]) begin
            fault_d = 1'b1;
          end else begin
            accept = 1'b1;
            st_d   = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid) begin
          if (last) begin
            st_d = post_q ? ST_WB : ST_FIN;
          end else begin
            step = 1'b1;
            st_d = ST_ISSUE;
          end
        end
      end
      ST_WB:   st_d = ST_FIN;
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      undef_q <= undef_d;
      fault_q <= fault_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      load_q <= 1'b0;
      wide_q <= 1'b0;
      post_q <= 1'b0;
      imm_q  <= 1'b0;
      rn_q   <= '0;
      reg_q  <= '0;
      elem_q <= '0;
      addr_q <= '0;
      base_q <= '0;
      off_q  <= '0;
    end else if (accept) begin
      dec_q  <= dec;
      load_q <= ins_load;
      wide_q <= ins_q;
      post_q <= ins_post;
      imm_q  <= (ins_rm == SP_IDX);
      rn_q   <= ins_rn;
      reg_q  <= ins_rt;
      elem_q <= '0;
      addr_q <= gpr_base_val;
      base_q <= gpr_base_val;
      off_q  <= gpr_off_val;
    end else if (step) begin
      reg_q  <= reg_q + RW'(1);
      elem_q <= elem_q + 3'd1;
      addr_q <= addr_q + ebytes;
    end
  end

  assign busy         = (st_q != ST_IDLE);
  assign done         = (st_q == ST_FIN);
  assign undef        = undef_q;
  assign align_fault  = fault_q;
  assign gpr_base_idx = ins_rn;
  assign gpr_off_idx  = ins_rm;
  assign base_we      = (st_q == ST_WB);
  assign base_widx    = rn_q;
  assign base_wval    = base_q + (imm_q ? total : off_q);
  assign vr_idx       = reg_q;
  assign vr_we        = (st_q == ST_WAIT) && mem_rvalid && load_q;
  assign vr_wdata     = merged;
  assign mem_req      = (st_q == ST_ISSUE);
  assign mem_we       = mem_req && !load_q;
  assign mem_size     = dec_q.scale;
  assign mem_addr     = addr_q;
  assign mem_wdata    = lane_out;
endmodule

// File: rtl/lss_chk.sv
module lss_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic undef,
  input logic align_fault,
  input logic base_we,
  input logic vr_we,
  input logic mem_req,
  input logic mem_rvalid
);
  a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r2_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (undef || align_fault) |-> (!mem_req && !vr_we && !base_we && !busy));

  a_r2_undef_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    undef |=> !undef);

  a_r7_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |=> !align_fault);

  a_r4_write_on_response: assert property (@(posedge clk) disable iff (!rst_n)
    vr_we |-> mem_rvalid);

  a_r8_wb_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> done);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, undef, align_fault}));
endmodule

bind lane_struct_seq lss_chk i_lss_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .undef       (undef),
  .align_fault (align_fault),
  .base_we     (base_we),
  .vr_we       (vr_we),
  .mem_req     (mem_req),
  .mem_rvalid  (mem_rvalid)
);

// File: tb/test_lane_struct_seq.sv
module test_lane_struct_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 1'b0, ins_q = 1'b0, ins_load = 1'b0, ins_r = 1'b0, ins_s = 1'b0, ins_post = 1'b0;
  logic [2:0] ins_opc = '0;
  logic [1:0] ins_size = '0;
  logic [4:0] ins_rt = '0, ins_rn = '0, ins_rm = '0;
  logic busy, done, undef, align_fault, base_we, vr_we, mem_req, mem_we;
  logic [4:0] gpr_base_idx, gpr_off_idx, base_widx, vr_idx;
  logic [63:0] gpr_base_val, gpr_off_val, base_wval, mem_addr, mem_wdata, mem_rdata;
  logic [127:0] vr_rdata, vr_wdata;
  logic [1:0] mem_size;
  logic mem_rvalid;

  logic [127:0] vrf [32];
  logic [63:0]  gpr [32];
  logic [63:0]  pend_a;
  logic [1:0]   cnt = '0;
  logic [1:0]   lat = 2'd1;
  logic [63:0]  log_a [8];
  logic [63:0]  log_d [8];
  logic [1:0]   log_s [8];
  int           log_n = 0;
  int errors = 0, checks = 0;

  lane_struct_seq i_lane_struct_seq (.*);

  function automatic logic [63:0] memfn(input logic [63:0] a);
    logic [63:0] v;
    for (int b = 0; b < 8; b++) begin
      logic [63:0] x;
      x = a + 64'(b);
      v[b*8 +: 8] = (x[7:0] ^ {x[11:8], x[15:12]}) + 8'h35;
    end
    return v;
  endfunction

  assign vr_rdata     = vrf[vr_idx];
  assign gpr_base_val = gpr[gpr_base_idx];
  assign gpr_off_val  = gpr[gpr_off_idx];
  assign mem_rvalid   = (cnt == 2'd1);
  assign mem_rdata    = memfn(pend_a);

  always @(posedge clk) begin
    if (vr_we) vrf[vr_idx] <= vr_wdata;
    if (base_we) gpr[base_widx] <= base_wval;
    if (mem_req) begin
      pend_a <= mem_addr;
      cnt <= lat;
      if (mem_we && log_n < 8) begin
        log_a[log_n] <= mem_addr;
        log_d[log_n] <= mem_wdata;
        log_s[log_n] <= mem_size;
      end
      if (mem_we) log_n <= log_n + 1;
    end else if (cnt != 2'd0) begin
      cnt <= cnt - 2'd1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input int op, input logic q, l, r, s, post, input logic [2:0] opc,
                        input logic [1:0] size, input logic [4:0] rt, rn, rm, input logic mis);
    logic [127:0] ev [32];
    logic [63:0]  eg [32];
    logic [63:0]  ea [4];
    logic [63:0]  ed [4];
    logic [1:0]   sc;
    logic [3:0]   lane;
    logic und, rep, flt;
    int ne, eb, kind, cyc;
    logic [63:0] base, d;
    // fresh register and memory-side state
    for (int i = 0; i < 32; i++) begin
      vrf[i] = {32'(i), 32'(op), ~32'(i), 32'hC0DE_0000 + 32'(op * 3)};
      gpr[i] = 64'h0010_0000 * 64'(i + 1) + 64'(op) * 64'h30;
    end
    gpr[31] = 64'h0000_7FF0_0000 + 64'(op) * 64'h100 + (mis ? 64'h4 : 64'h0);
    log_n = 0;
    lat = (op % 2 == 0) ? 2'd1 : 2'd2;
    for (int i = 0; i < 32; i++) begin ev[i] = vrf[i]; eg[i] = gpr[i]; end
    // R1/R2 decode model from the requirement text
    und = 1'b0; rep = 1'b0; lane = '0; sc = opc[2:1];
    case (opc[2:1])
      2'd0: lane = {q, s, size};
      2'd1: begin und = size[0]; lane = {1'b0, q, s, size[1]}; end
      2'd2: if (size[1]) und = 1'b1;
            else if (!size[0]) lane = {2'b0, q, s};
            else begin und = s; lane = {3'b0, q}; sc = 2'd3; end
      default: begin und = !l || s; sc = size; rep = 1'b1; end
    endcase
    ne = int'({opc[0], r}) + 1;
    eb = 1 << sc;
    base = gpr[rn];
    flt = !und && rn == 5'd31 && base[3:0] != 4'd0;
    if (!und && !flt) begin
      for (int e = 0; e < ne; e++) begin
        int rg;
        rg = (int'(rt) + e) % 32;
        ea[e] = base + 64'(e * eb);
        ed[e] = '0;
        if (l) begin
          d = memfn(ea[e]);
          if (rep) begin
            for (int bb = 0; bb < 16; bb++)
              ev[rg][bb*8 +: 8] = (bb < (q ? 16 : 8)) ? d[(bb % eb)*8 +: 8] : 8'h00;
          end else begin
            for (int bb = 0; bb < eb; bb++)
              ev[rg][(int'(lane)*eb + bb)*8 +: 8] = d[bb*8 +: 8];
          end
        end else begin
          for (int bb = 0; bb < eb; bb++)
            ed[e][bb*8 +: 8] = ev[rg][(int'(lane)*eb + bb)*8 +: 8];
        end
      end
      if (post) eg[rn] = base + ((rm == 5'd31) ? 64'(ne * eb) : gpr[rm]);
    end
    // drive one start cycle
    @(negedge clk);
    ins_q = q; ins_load = l; ins_r = r; ins_s = s; ins_post = post;
    ins_opc = opc; ins_size = size; ins_rt = rt; ins_rn = rn; ins_rm = rm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    kind = 0; cyc = 0;
    while (kind == 0 && cyc < 200) begin
      if (done) kind = 1;
      else if (undef) kind = 2;
      else if (align_fault) kind = 3;
      else begin @(negedge clk); cyc++; end
    end
    if (und) check(kind == 2, "R2 undef pulse", 128'(kind), 128'd2);
    else if (flt) check(kind == 3, "R7 align fault", 128'(kind), 128'd3);
    else check(kind == 1, "R11 done", 128'(kind), 128'd1);
    @(negedge clk);
    check(!busy && !done && !undef && !align_fault, "R11 idle after end",
          128'({busy, done, undef, align_fault}), 128'd0);
    for (int i = 0; i < 32; i++) begin
      if (vrf[i] !== ev[i]) begin
        check(1'b0, l ? (rep ? "R5 replicate" : "R4 lane merge / R3 order") : "R6 store no write",
              vrf[i], ev[i]);
        break;
      end
      if (i == 31) check(1'b1, "R3 vector file", '0, '0);
    end
    for (int i = 0; i < 32; i++) begin
      if (gpr[i] !== eg[i]) begin
        check(1'b0, post ? "R8 writeback" : "R9 no writeback", 128'(gpr[i]), 128'(eg[i]));
        break;
      end
      if (i == 31) check(1'b1, "R8 R9 base regs", '0, '0);
    end
    if (!l && !und && !flt) begin
      check(log_n == ne, "R10 R3 store access count", 128'(log_n), 128'(ne));
      for (int e = 0; e < ne && e < log_n; e++) begin
        check(log_a[e] == ea[e] && log_s[e] == sc, "R3 store address/size",
              {log_a[e], 62'd0, log_s[e]}, {ea[e], 62'd0, sc});
        check(log_d[e] == ed[e], "R6 store data", 128'(log_d[e]), 128'(ed[e]));
      end
    end else begin
      check(log_n == 0, "R2 R7 no store access", 128'(log_n), 128'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int op;
    for (int i = 0; i < 32; i++) begin vrf[i] = '0; gpr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !undef && !align_fault && !mem_req && !vr_we && !base_we,
          "R11 reset state", 128'({busy, done, undef, align_fault, mem_req, vr_we, base_we}), 128'd0);
    op = 0;
    for (int opc = 0; opc < 8; opc++)
      for (int r = 0; r < 2; r++)
        for (int s = 0; s < 2; s++)
          for (int sz = 0; sz < 4; sz++)
            for (int q = 0; q < 2; q++)
              for (int l = 0; l < 2; l++)
                for (int p = 0; p < 2; p++) begin
                  logic [4:0] rt, rn, rm;
                  rt = 5'((op * 7) % 32);
                  rn = (op % 5 == 0) ? 5'd31 : 5'(op % 31);
                  rm = (op % 3 == 0) ? 5'd31 : 5'((op % 29) + 1);
                  run_op(op, q[0], l[0], r[0], s[0], p[0], 3'(opc), 2'(sz), rt, rn, rm, (op % 4) == 1);
                  op++;
                end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule